// File: doc/BRIEF.md
# Voltage-Scaling Serial Bus Master Frame Engine

This block is the controller end of a three-wire serial link to a point-of-load regulator. The controller owns the bus clock and the outgoing data line. The regulator answers on a third line. When a request arrives, the engine builds a 32-bit outgoing subframe. The subframe holds a fixed start code, a command, a group bit, a data type, a selector and a 16-bit payload, and ends with a 3-bit check code. The engine shifts this subframe out most significant bit first. In the same 32 bus clocks it shifts in the 32-bit reply subframe and checks the reply's check code.

Two request paths feed the engine. The first is a general path that carries every field. The second is a small front end for the voltage loop, with three single-bit requests: raise, lower and hold. Each of these becomes a commit-type write frame with a dedicated data-type code. The bus clock comes from the system clock through a programmable divider. Outgoing data changes on the falling edge of the bus clock, and incoming data is taken on the rising edge. A check-code failure in the reply sets a sticky error flag. The frame still completes and busy still drops.

Top module: `avs_master_engine`

## Requirements
- R1: After reset, avs_clk is 1, avs_mdata is 0, and busy, done and crc_error are 0.
- R2: The outgoing subframe is sent MSB first. Its bits, from bit 31 down to bit 0, are: [31:30] start code 01, [29:28] command, [27] group, [26:23] data type, [22:19] selector, [18:3] payload, [2:0] check code.
- R3: The check code is the remainder of the top 29 bits (bit 31 first) divided by x^3+x^2+x, using a 3-bit shift register that starts at 000. The feedback bit is the input bit XOR register bit 2, and the register shifts left and is XORed with 110 when the feedback bit is 1.
- R4: Within a frame, avs_mdata changes only together with a falling edge of avs_clk, and never while avs_clk stays high. avs_sdata is taken at each rising edge of avs_clk, MSB first.
- R5: Each high half and each low half of avs_clk lasts div_ratio+1 system clocks. Each frame has exactly 32 bus clock pulses, and avs_clk rests at 1 between frames.
- R6: When done pulses, rsp_word holds the 32 received bits, with the first received bit in bit 31. crc_error is 1 exactly when the R3 register, run over all 32 received bits, ends nonzero. The flag holds until the next frame is accepted, and it clears at that acceptance.
- R7: busy rises on the clock edge after a request is seen while idle, and stays high until done. Requests that arrive while busy are ignored: they neither change the frame in progress nor start another one.
- R8: A raise request sends command 00, group 0, data type 0111, selector 0000 and payload 0. A lower request sends data type 0110, and a hold request sends data type 1000, with the other fields the same.
- R9: When several requests arrive together, the priority is: general request, then raise, then lower, then hold.
- R10: done is a single-cycle pulse. busy falls in the same cycle that done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | DIV_W | Bus clock half period, minus one, in system clocks |
| req_valid | input | 1 | General frame request |
| req_cmd | input | 2 | Command code for the general request |
| req_group | input | 1 | Group bit for the general request |
| req_dtype | input | 4 | Data type for the general request |
| req_sel | input | 4 | Selector for the general request |
| req_data | input | 16 | Payload for the general request |
| vreq_up | input | 1 | Raise-voltage request |
| vreq_down | input | 1 | Lower-voltage request |
| vreq_hold | input | 1 | Hold-voltage request |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| crc_error | output | 1 | The last reply failed its check code |
| rsp_word | output | 32 | Last received reply subframe |
| avs_clk | output | 1 | Bus clock |
| avs_mdata | output | 1 | Controller data line |
| avs_sdata | input | 1 | Regulator reply data line |

## Verification
The hardest case to reach from the ports is a request that arrives while a frame is being shifted. The request must leave no trace in the current frame and must not start another one. The stimulus pulses general and voltage requests in the middle of a frame, then compares the captured bus bits with the first frame. It also watches busy for several cycles after done. Replies with a valid check code and replies with one bit flipped are mixed at random. Bus divider settings vary between frames, and every half period is timed against the system clock.

// File: rtl/avs_pkg.sv
package avs_pkg;
  localparam int SUBFRAME_W = 32;
  localparam int CRC_W      = 3;
  localparam int HDR_W      = SUBFRAME_W - CRC_W;
  localparam int DATA_W     = 16;
  localparam int DTYPE_W    = 4;
  localparam int SEL_W      = 4;

  localparam logic [1:0]       START_CODE = 2'b01;
  localparam logic [CRC_W-1:0] CRC_POLY   = 3'b110;

  typedef enum logic [1:0] {
    CMD_COMMIT = 2'b00,
    CMD_KEEP   = 2'b01,
    CMD_RSVD   = 2'b10,
    CMD_READ   = 2'b11
  } avs_cmd_e;

  localparam logic [DTYPE_W-1:0] DT_STEP_DOWN = 4'b0110;
  localparam logic [DTYPE_W-1:0] DT_STEP_UP   = 4'b0111;
  localparam logic [DTYPE_W-1:0] DT_HOLD      = 4'b1000;

  typedef struct packed {
    logic [1:0]         cmd;
    logic               grp;
    logic [DTYPE_W-1:0] dtype;
    logic [SEL_W-1:0]   sel;
    logic [DATA_W-1:0]  data;
  } avs_hdr_t;
endpackage

// File: rtl/avs_crc3.sv
module avs_crc3
  import avs_pkg::*;
#(
  parameter int IN_W = 29
) (
  input  logic [IN_W-1:0]  bits_i,
  output logic [CRC_W-1:0] rem_o
);
  logic [CRC_W-1:0] r;
  logic             fb;

  always_comb begin
    r  = '0;
    fb = 1'b0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb = bits_i[i] ^ r[CRC_W-1];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    rem_o = r;
  end
endmodule

// File: rtl/avs_req_mux.sv
module avs_req_mux
  import avs_pkg::*;
(
  input  logic               gen_valid_i,
  input  avs_hdr_t           gen_hdr_i,
  input  logic               up_i,
  input  logic               down_i,
  input  logic               hold_i,
  output logic               sel_valid_o,
  output avs_hdr_t           sel_hdr_o
);
  localparam int NSRC = 4;

  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] grant;
  avs_hdr_t        hdr_tab [NSRC];

  assign raw = {hold_i, down_i, up_i, gen_valid_i};

  always_comb begin
    hdr_tab[0] = gen_hdr_i;
    hdr_tab[1] = '{cmd: CMD_COMMIT, grp: 1'b0, dtype: DT_STEP_UP,   sel: '0, data: '0};
    hdr_tab[2] = '{cmd: CMD_COMMIT, grp: 1'b0, dtype: DT_STEP_DOWN, sel: '0, data: '0};
    hdr_tab[3] = '{cmd: CMD_COMMIT, grp: 1'b0, dtype: DT_HOLD,      sel: '0, data: '0};
  end

  // fixed priority: lowest index wins (R9)
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_pri
      if (g == 0) begin : g_first
        assign grant[g] = raw[g];
      end else begin : g_rest
        assign grant[g] = raw[g] & ~|raw[g-1:0];
      end
    end
  endgenerate

  always_comb begin
    sel_hdr_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) sel_hdr_o = hdr_tab[i];
    end
  end

  assign sel_valid_o = |raw;

  always_comb begin
    a_r9_one_grant: assert ($onehot0(grant));
    a_r9_grant_when_raw: assert ((|raw) == (|grant));
  end
endmodule

// File: rtl/avs_clk_div.sv
module avs_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || !run_i) cnt_d = '0;
    else if (tick_o)         cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/avs_shift_core.sv
module avs_shift_core
  import avs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [SUBFRAME_W-1:0] frame_i,
  input  logic                  tick_i,
  input  logic                  sdata_i,
  output logic                  run_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  crc_err_o,
  output logic [SUBFRAME_W-1:0] rx_word_o,
  output logic                  sclk_o,
  output logic                  mdata_o
);
  localparam int CNT_W = $clog2(SUBFRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SUBFRAME_W - 1);

  typedef enum logic {ST_IDLE, ST_SHIFT} st_e;

  st_e                   st_q, st_d;
  logic                  ph_q, ph_d;
  logic [CNT_W-1:0]      bit_q, bit_d;
  logic [SUBFRAME_W-1:0] tx_q, tx_d;
  logic [SUBFRAME_W-1:0] rx_q, rx_d;
  logic [SUBFRAME_W-1:0] rsp_q, rsp_d;
  logic                  sclk_q, sclk_d;
  logic                  md_q, md_d;
  logic                  done_q, done_d;
  logic                  err_q, err_d;
  logic [CRC_W-1:0]      chk_rem;

  avs_crc3 #(.IN_W(SUBFRAME_W)) u_rx_chk (
    .bits_i (rx_q),
    .rem_o  (chk_rem)
  );

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    rsp_d  = rsp_q;
    sclk_d = sclk_q;
    md_d   = md_q;
    err_d  = err_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_SHIFT;
          ph_d   = 1'b0;
          bit_d  = '0;
          sclk_d = 1'b0;
          md_d   = frame_i[SUBFRAME_W-1];
          tx_d   = {frame_i[SUBFRAME_W-2:0], 1'b0};
          err_d  = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (tick_i) begin
          if (!ph_q) begin
            sclk_d = 1'b1;
            rx_d   = {rx_q[SUBFRAME_W-2:0], sdata_i};
            ph_d   = 1'b1;
          end else if (bit_q == LAST_BIT) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            rsp_d  = rx_q;
            err_d  = |chk_rem;
          end else begin
            sclk_d = 1'b0;
            md_d   = tx_q[SUBFRAME_W-1];
            tx_d   = {tx_q[SUBFRAME_W-2:0], 1'b0};
            bit_d  = bit_q + 1'b1;
            ph_d   = 1'b0;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rsp_q  <= '0;
      sclk_q <= 1'b1;
      md_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      rsp_q  <= rsp_d;
      sclk_q <= sclk_d;
      md_q   <= md_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign run_o     = (st_q == ST_SHIFT);
  assign busy_o    = (st_q == ST_SHIFT);
  assign done_o    = done_q;
  assign crc_err_o = err_q;
  assign rx_word_o = rsp_q;
  assign sclk_o    = sclk_q;
  assign mdata_o   = md_q;

  a_r4_mdata_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mdata_o));
  a_r5_clk_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_busy_falls_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  a_r7_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r6_err_moves_at_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(crc_err_o) |-> (done_o || busy_o));
endmodule

// File: rtl/avs_master_engine.sv
module avs_master_engine
  import avs_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             req_valid,
  input  logic [1:0]       req_cmd,
  input  logic             req_group,
  input  logic [3:0]       req_dtype,
  input  logic [3:0]       req_sel,
  input  logic [15:0]      req_data,
  input  logic             vreq_up,
  input  logic             vreq_down,
  input  logic             vreq_hold,
  output logic             busy,
  output logic             done,
  output logic             crc_error,
  output logic [31:0]      rsp_word,
  output logic             avs_clk,
  output logic             avs_mdata,
  input  logic             avs_sdata
);
  avs_hdr_t              gen_hdr;
  avs_hdr_t              sel_hdr;
  logic                  sel_valid;
  logic                  accept;
  logic                  run;
  logic                  tick;
  logic [HDR_W-1:0]      hdr_bits;
  logic [CRC_W-1:0]      tx_crc;
  logic [SUBFRAME_W-1:0] frame;

  assign gen_hdr = '{cmd: req_cmd, grp: req_group, dtype: req_dtype,
                     sel: req_sel, data: req_data};

  avs_req_mux u_mux (
    .gen_valid_i (req_valid),
    .gen_hdr_i   (gen_hdr),
    .up_i        (vreq_up),
    .down_i      (vreq_down),
    .hold_i      (vreq_hold),
    .sel_valid_o (sel_valid),
    .sel_hdr_o   (sel_hdr)
  );

  assign hdr_bits = {START_CODE, sel_hdr};

  avs_crc3 #(.IN_W(HDR_W)) u_tx_crc (
    .bits_i (hdr_bits),
    .rem_o  (tx_crc)
  );

  assign frame  = {hdr_bits, tx_crc};
  assign accept = sel_valid && !busy;

  avs_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .restart_i (accept),
    .div_i     (div_ratio),
    .tick_o    (tick)
  );

  avs_shift_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (accept),
    .frame_i   (frame),
    .tick_i    (tick),
    .sdata_i   (avs_sdata),
    .run_o     (run),
    .busy_o    (busy),
    .done_o    (done),
    .crc_err_o (crc_error),
    .rx_word_o (rsp_word),
    .sclk_o    (avs_clk),
    .mdata_o   (avs_mdata)
  );

  a_r7_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
endmodule

// File: tb/tb_avs_master_engine.sv
`timescale 1ns/1ps
module tb_avs_master_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  div_ratio;
  logic        req_valid, req_group, vreq_up, vreq_down, vreq_hold;
  logic [1:0]  req_cmd;
  logic [3:0]  req_dtype, req_sel;
  logic [15:0] req_data;
  logic        busy, done, crc_error, avs_clk, avs_mdata;
  logic        avs_sdata;
  logic [31:0] rsp_word;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  avs_master_engine dut (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_group(req_group),
    .req_dtype(req_dtype), .req_sel(req_sel), .req_data(req_data),
    .vreq_up(vreq_up), .vreq_down(vreq_down), .vreq_hold(vreq_hold),
    .busy(busy), .done(done), .crc_error(crc_error), .rsp_word(rsp_word),
    .avs_clk(avs_clk), .avs_mdata(avs_mdata), .avs_sdata(avs_sdata)
  );

  // regulator model and bus timing monitor
  logic [31:0] sl_resp, cap;
  int sl_idx, pcount, period_bad, cur_div, cyc;
  int t_fall, t_rise;
  bit have_rise;

  always @(negedge clk) cyc++;

  always @(negedge avs_clk) begin
    if (have_rise && (cyc - t_rise != cur_div + 1)) period_bad++;
    t_fall = cyc;
    avs_sdata = (sl_idx < 32) ? sl_resp[31 - sl_idx] : 1'b0;
    sl_idx++;
  end

  always @(posedge avs_clk) begin
    if (cyc - t_fall != cur_div + 1) period_bad++;
    t_rise    = cyc;
    have_rise = 1'b1;
    cap       = {cap[30:0], avs_mdata};
    pcount++;
  end

  function automatic logic [2:0] crc_rem(input logic [31:0] w, input int n);
    logic [2:0] r = 3'b000;
    logic fb;
    for (int i = 31; i >= 32 - n; i--) begin
      fb = w[i] ^ r[2];
      r  = {r[1:0], 1'b0} ^ (fb ? 3'b110 : 3'b000);
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_frame(input logic [1:0] c, input logic g,
      input logic [3:0] dt, input logic [3:0] se, input logic [15:0] d);
    logic [31:0] w = {2'b01, c, g, dt, se, d, 3'b000};
    w[2:0] = crc_rem(w, 29);
    return w;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic arm(input logic [31:0] resp, input int dv);
    sl_resp = resp; sl_idx = 0; pcount = 0; period_bad = 0;
    have_rise = 1'b0; cap = '0; cur_div = dv; div_ratio = 8'(dv);
  endtask

  task automatic drive(input logic gv, input logic up, input logic dn, input logic hd,
      input logic [1:0] c, input logic g, input logic [3:0] dt, input logic [3:0] se,
      input logic [15:0] d);
    req_valid = gv; vreq_up = up; vreq_down = dn; vreq_hold = hd;
    req_cmd = c; req_group = g; req_dtype = dt; req_sel = se; req_data = d;
  endtask

  task automatic idle_inputs();
    drive(0, 0, 0, 0, 2'b00, 0, 4'h0, 4'h0, 16'h0);
  endtask

  task automatic finish_frame(input logic [31:0] expf, input logic [31:0] resp,
                              input string tag);
    while (!done) @(negedge clk);
    chk(cap == expf, {tag, " R2 R3 frame bits"}, cap, expf);
    chk(pcount == 32, {tag, " R5 pulse count"}, pcount, 32);
    chk(period_bad == 0, {tag, " R5 R4 half periods"}, period_bad, 0);
    chk(rsp_word == resp, {tag, " R6 reply word"}, rsp_word, resp);
    chk(crc_error == (crc_rem(resp, 32) != 3'b000), {tag, " R6 crc flag"},
        crc_error, crc_rem(resp, 32) != 3'b000);
    chk(!busy, {tag, " R10 busy falls with done"}, busy, 0);
    @(negedge clk);
    chk(!done, {tag, " R10 done one cycle"}, done, 0);
  endtask

  task automatic do_frame(input logic gv, input logic up, input logic dn, input logic hd,
      input logic [1:0] c, input logic g, input logic [3:0] dt, input logic [3:0] se,
      input logic [15:0] d, input logic [31:0] resp, input int dv,
      input logic [31:0] expf, input string tag);
    @(negedge clk);
    arm(resp, dv);
    drive(gv, up, dn, hd, c, g, dt, se, d);
    @(negedge clk);
    idle_inputs();
    chk(busy, {tag, " R7 busy after accept"}, busy, 1);
    finish_frame(expf, resp, tag);
  endtask

  function automatic logic [31:0] good_resp(input logic [31:0] raw);
    logic [31:0] w = {raw[31:3], 3'b000};
    w[2:0] = crc_rem(w, 29);
    return w;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, ef;
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0; avs_sdata = 1'b0; cyc = 0; sl_idx = 99;
    arm(32'h0, 0);
    idle_inputs();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(avs_clk == 1'b1, "R1 avs_clk reset", avs_clk, 1);
    chk(avs_mdata == 1'b0, "R1 avs_mdata reset", avs_mdata, 0);
    chk({busy, done, crc_error} == 3'b000, "R1 status reset", {busy, done, crc_error}, 0);

    // R8 voltage requests, each alone
    r = good_resp(32'h12345678);
    do_frame(0, 1, 0, 0, 2'b00, 0, 0, 0, 0, r, 1, mk_frame(2'b00, 0, 4'b0111, 0, 0), "R8 up");
    do_frame(0, 0, 1, 0, 2'b00, 0, 0, 0, 0, r, 0, mk_frame(2'b00, 0, 4'b0110, 0, 0), "R8 down");
    do_frame(0, 0, 0, 1, 2'b00, 0, 0, 0, 0, r ^ 32'h10, 2, mk_frame(2'b00, 0, 4'b1000, 0, 0), "R8 hold");

    // R9 priority
    do_frame(1, 1, 1, 1, 2'b11, 0, 4'h0, 4'h3, 16'hBEEF, r, 1,
             mk_frame(2'b11, 0, 4'h0, 4'h3, 16'hBEEF), "R9 general first");
    do_frame(0, 1, 1, 1, 2'b11, 1, 4'hF, 4'hF, 16'hFFFF, r, 0,
             mk_frame(2'b00, 0, 4'b0111, 0, 0), "R9 up over down");
    do_frame(0, 0, 1, 1, 2'b11, 1, 4'hF, 4'hF, 16'hFFFF, r, 0,
             mk_frame(2'b00, 0, 4'b0110, 0, 0), "R9 down over hold");

    // R5 long half period
    do_frame(1, 0, 0, 0, 2'b01, 0, 4'h0, 4'hA, 16'h0384, ~r, 20,
             mk_frame(2'b01, 0, 4'h0, 4'hA, 16'h0384), "R5 slow clock");

    // R7 requests during a frame are ignored
    @(negedge clk);
    r = good_resp(32'hCAFE0000);
    arm(r, 2);
    drive(1, 0, 0, 0, 2'b11, 0, 4'hE, 4'h1, 16'h0001);
    ef = mk_frame(2'b11, 0, 4'hE, 4'h1, 16'h0001);
    @(negedge clk);
    drive(1, 1, 1, 1, 2'b00, 1, 4'h5, 4'h9, 16'hA5A5);
    repeat (60) @(negedge clk);
    idle_inputs();
    finish_frame(ef, r, "R7 ignore while busy");
    begin
      bit stayed = 1'b1;
      repeat (10) begin
        @(negedge clk);
        if (busy || !avs_clk) stayed = 1'b0;
      end
      chk(stayed, "R7 no frame started by busy-time request", stayed, 1);
    end

    // R6 crc error cleared on next accept
    do_frame(0, 0, 0, 1, 2'b00, 0, 0, 0, 0, r ^ 32'h1, 0,
             mk_frame(2'b00, 0, 4'b1000, 0, 0), "R6 bad reply");
    @(negedge clk);
    arm(r, 0);
    drive(0, 1, 0, 0, 2'b00, 0, 0, 0, 0);
    @(negedge clk);
    idle_inputs();
    chk(!crc_error, "R6 flag cleared at accept", crc_error, 0);
    finish_frame(mk_frame(2'b00, 0, 4'b0111, 0, 0), r, "R6 clean reply");

    // random general frames
    for (int k = 0; k < 24; k++) begin
      logic [1:0] c = 2'($urandom);
      logic g = 1'($urandom);
      logic [3:0] dt = 4'($urandom);
      logic [3:0] se = 4'($urandom);
      logic [15:0] d = 16'($urandom);
      logic [31:0] rr = good_resp($urandom);
      int dv = int'($urandom % 4);
      if ($urandom % 3 == 0) rr = rr ^ (32'h1 << ($urandom % 32));
      do_frame(1, 0, 0, 0, c, g, dt, se, d, rr, dv, mk_frame(c, g, dt, se, d), "R2 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule